// File: doc/BRIEF.md
# Multi-Mode Timer with PWM and Capture

This block is a general-purpose timer built around a single counter and one external pin. Software picks one of three pin modes through a small register port. In PWM mode the block drives the pin with a waveform whose period and high time are both programmable. In edge-count mode the pin acts as a clock input, and the counter advances once for each rising edge seen on it. In capture mode the pin is a measurement input, and the block latches the high-pulse width and the rise-to-rise period of the incoming signal. Capture mode can resolve serial bit times for baud-rate detection.

In PWM and capture modes, the counter advances on the system clock or on the rising edges of one of two external clock inputs. Every external input passes through a synchronizer and an edge detector before the counter uses it. A period event or a period capture raises a one-cycle interrupt pulse. A counter wrap in capture mode sets a sticky overflow flag and raises a separate error pulse.

Top module: `mmt_timer`

Register map (address on `reg_addr`, data width CNT_W):
- 0 control: bits [1:0] mode (0 idle, 1 PWM, 2 edge count, 3 capture), bits [3:2] tick source (0 or 3 system clock, 1 `ext_clk_a`, 2 `ext_clk_b`), bit 4 interrupt enable.
- 1 period, 2 high width, 3 captured period (read only), 4 captured width (read only), 5 status (bit 0 overflow), 6 live count (read only).

## Requirements
- R1: After reset, every register reads 0, and `pin_oe`, `pin_out`, `irq` and `err_irq` are all low.
- R2: In PWM mode `pin_oe` is high, and within every PERIOD ticks `pin_out` is high for exactly WIDTH ticks. Outside PWM mode `pin_out` stays low.
- R3: In PWM mode, a WIDTH of 0 keeps `pin_out` low at all times. A WIDTH of PERIOD or more keeps it high at all times.
- R4: In PWM and edge-count modes the counter returns to 0 after reaching PERIOD-1. If control bit 4 is set, this wrap gives exactly one `irq` pulse. If bit 4 is clear, `irq` never rises.
- R5: In edge-count mode the count (address 6) advances by one for each rising edge on `pin_in`, counted modulo PERIOD. `pin_oe` stays low in this mode.
- R6: In capture mode, captured width (address 4) holds the number of ticks `pin_in` was high. Captured period (address 3) holds the number of ticks between successive rising edges. Each period capture gives one `irq` pulse.
- R7: The first rising edge after capture mode is entered only starts measurement. It latches no period and raises no `irq`.
- R8: A counter wrap in capture mode sets status bit 0 and gives one `err_irq` pulse when interrupts are enabled. The bit stays set until 1 is written to status bit 0.
- R9: Control bits [3:2] select the tick source. Edges on the clock input that is not selected do not advance the counter.
- R10: Any write to the control register restarts the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Registered read data for the address of the previous cycle |
| pin_in | input | 1 | Timer pin, input side |
| pin_out | output | 1 | Timer pin, output side (PWM waveform) |
| pin_oe | output | 1 | Timer pin output enable |
| ext_clk_a | input | 1 | First external clock input |
| ext_clk_b | input | 1 | Second external clock input |
| irq | output | 1 | Period or capture interrupt pulse |
| err_irq | output | 1 | Capture overflow interrupt pulse |

## Verification
The bench builds the timer with CNT_W = 8 and the default two-stage synchronizer. With an 8-bit counter, a wrap in capture mode takes only 256 system clocks, so the overflow flag, its error pulse and its clearing can all be reached in a short run. Short periods such as 3, 4 and 10 bring several PWM and edge-count wraps into a window of a few dozen cycles. There, pulse counts and high-time totals do not depend on the phase of the waveform.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_EDGE = 2'd2,
    MODE_CAPT = 2'd3
  } mmt_mode_e;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_EXTA = 2'd1,
    SRC_EXTB = 2'd2,
    SRC_SYS2 = 2'd3
  } mmt_src_e;

  // bit 4 enable, bits 3:2 source, bits 1:0 mode
  typedef struct packed {
    logic      ien;
    mmt_src_e  src;
    mmt_mode_e mode;
  } mmt_ctrl_t;

  localparam int CTRL_W = $bits(mmt_ctrl_t);

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_WID  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CPER = 3'd3;
  localparam logic [ADDR_W-1:0] A_CWID = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;

endpackage

// File: rtl/mmt_sync.sv
// Multi-flop synchronizer; exposes the synchronized level and its one-cycle-old copy
module mmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl,
  output logic lvl_d
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      lvl_d <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      lvl_d <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];

endmodule

// File: rtl/mmt_regs.sv
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cap_period,
  input  logic [CNT_W-1:0]  cap_width,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovf_set,
  output mmt_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  width,
  output logic              ovf,
  output logic              ctrl_wr,
  output logic [CNT_W-1:0]  rdata
);

  logic ovf_clr;

  assign ctrl_wr = wr && (addr == A_CTRL);
  assign ovf_clr = wr && (addr == A_STAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      period <= '0;
      width  <= '0;
      ovf    <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_CTRL:  ctrl   <= mmt_ctrl_t'(wdata[CTRL_W-1:0]);
          A_PER:   period <= wdata;
          A_WID:   width  <= wdata;
          default: ;
        endcase
      end
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;

      case (addr)
        A_CTRL:  rdata <= {{(CNT_W-CTRL_W){1'b0}}, ctrl};
        A_PER:   rdata <= period;
        A_WID:   rdata <= width;
        A_CPER:  rdata <= cap_period;
        A_CWID:  rdata <= cap_width;
        A_STAT:  rdata <= {{(CNT_W-1){1'b0}}, ovf};
        A_CNT:   rdata <= count;
        default: rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mmt_core.sv
// Shared counter serving PWM generation, pin edge counting and width/period capture
module mmt_core
  import mmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  mmt_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  input  logic             restart,
  input  logic [1:0]       ext_rise,
  input  logic             pin_rise,
  input  logic             pin_fall,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_period,
  output logic [CNT_W-1:0] cap_width,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq,
  output logic             err_irq,
  output logic             ovf_set
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             tick;
  logic             armed;
  logic             wrap;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    case (ctrl.src)
      SRC_EXTA: tick = ext_rise[0];
      SRC_EXTB: tick = ext_rise[1];
      default:  tick = 1'b1;
    endcase
    if (ctrl.mode == MODE_EDGE) tick = pin_rise;
  end

  assign cnt_inc = cnt + CNT_ONE;
  assign wrap    = (cnt_inc == period);
  assign ovf_set = (ctrl.mode == MODE_CAPT) && !restart && !pin_rise
                   && tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      cap_period <= '0;
      cap_width  <= '0;
      armed      <= 1'b0;
      pin_out    <= 1'b0;
      pin_oe     <= 1'b0;
      irq        <= 1'b0;
      err_irq    <= 1'b0;
    end else begin
      irq     <= 1'b0;
      err_irq <= 1'b0;
      pin_oe  <= (ctrl.mode == MODE_PWM);
      pin_out <= (ctrl.mode == MODE_PWM) && (cnt < width);
      if (restart) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        case (ctrl.mode)
          MODE_PWM, MODE_EDGE: begin
            if (tick) begin
              if (wrap) begin
                cnt <= '0;
                irq <= ctrl.ien;
              end else begin
                cnt <= cnt_inc;
              end
            end
          end
          MODE_CAPT: begin
            if (pin_rise) begin
              if (armed) begin
                cap_period <= cnt;
                irq        <= ctrl.ien;
              end
              armed <= 1'b1;
              cnt   <= tick ? CNT_ONE : '0;
            end else begin
              if (pin_fall && armed) cap_width <= cnt;
              if (tick) begin
                if (cnt == CNT_MAX) begin
                  err_irq <= ctrl.ien;
                  armed   <= 1'b0;
                end
                cnt <= cnt_inc;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  input  logic              ext_clk_a,
  input  logic              ext_clk_b,
  output logic              irq,
  output logic              err_irq
);

  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] in_lvl;
  logic [NUM_IN-1:0] in_lvl_d;
  logic [NUM_IN-1:0] in_rise;
  logic              pin_fall;

  mmt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0]  period_q;
  logic [CNT_W-1:0]  width_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cap_period_q;
  logic [CNT_W-1:0]  cap_width_q;
  logic              ovf_flag;
  logic              ovf_set;
  logic              ctrl_wr;

  assign raw_in = {ext_clk_b, ext_clk_a, pin_in};

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    mmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d     (raw_in[gi]),
      .lvl   (in_lvl[gi]),
      .lvl_d (in_lvl_d[gi])
    );
  end

  assign in_rise  = in_lvl & ~in_lvl_d;
  assign pin_fall = ~in_lvl[0] & in_lvl_d[0];

  mmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .cap_period (cap_period_q),
    .cap_width  (cap_width_q),
    .count      (cnt_q),
    .ovf_set    (ovf_set),
    .ctrl       (ctrl_q),
    .period     (period_q),
    .width      (width_q),
    .ovf        (ovf_flag),
    .ctrl_wr    (ctrl_wr),
    .rdata      (reg_rdata)
  );

  mmt_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl_q),
    .period     (period_q),
    .width      (width_q),
    .restart    (ctrl_wr),
    .ext_rise   (in_rise[2:1]),
    .pin_rise   (in_rise[0]),
    .pin_fall   (pin_fall),
    .cnt        (cnt_q),
    .cap_period (cap_period_q),
    .cap_width  (cap_width_q),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq),
    .err_irq    (err_irq),
    .ovf_set    (ovf_set)
  );

endmodule

// File: rtl/mmt_timer_chk.sv
module mmt_timer_chk
  import mmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              irq,
  input logic              err_irq,
  input logic              ovf,
  input mmt_ctrl_t         ctrl
);

  // R2: the pin is never driven high while the output is not enabled
  a_r2_out_needs_oe: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);

  // R4: no interrupt unless the enable bit was set on the previous cycle
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl.ien) |-> !irq);

  // R8: an error pulse coincides with the overflow flag being set
  a_r8_err_sets_flag: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> ovf);

  // R8: the flag stays set until software clears it
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(reg_wr && reg_addr == A_STAT && reg_wdata[0])) |=> ovf);

  // R8: the error output is a single-cycle pulse
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_irq |=> !err_irq);

endmodule

bind mmt_timer mmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .err_irq   (err_irq),
  .ovf       (ovf_flag),
  .ctrl      (ctrl_q)
);

// File: tb/mmt_timer_tb.sv
module mmt_timer_tb;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic             pin_in = 1'b0;
  logic             pin_out;
  logic             pin_oe;
  logic             ext_clk_a = 1'b0;
  logic             ext_clk_b = 1'b0;
  logic             irq;
  logic             err_irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  int err_seen = 0;

  mmt_timer #(.CNT_W(CNT_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .ext_clk_a (ext_clk_a),
    .ext_clk_b (ext_clk_b),
    .irq       (irq),
    .err_irq   (err_irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (irq) irq_seen++;
    if (err_irq) err_seen++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = CNT_W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic pin_pulse(input int hi, input int lo);
    pin_in = 1'b1;
    repeat (hi) @(negedge clk);
    pin_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic ext_edges(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      if (which == 0) ext_clk_a = 1'b1; else ext_clk_b = 1'b1;
      repeat (3) @(negedge clk);
      if (which == 0) ext_clk_a = 1'b0; else ext_clk_b = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic high_in_window(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_out) hi++;
    end
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), v);
      check("R1 register reset value", v, 0);
    end
    check("R1 pin_oe after reset", int'(pin_oe), 0);
    check("R1 pin_out after reset", int'(pin_out), 0);
    check("R1 no irq after reset", irq_seen + err_seen, 0);
  endtask

  task automatic t_pwm();
    int hi;
    wr_reg(3'd1, 10);
    wr_reg(3'd2, 3);
    wr_reg(3'd0, 8'h11);
    repeat (20) @(negedge clk);
    check("R2 pin_oe in PWM mode", int'(pin_oe), 1);
    irq_seen = 0;
    high_in_window(50, hi);
    check("R2 high ticks over five periods", hi, 15);
    check("R4 one irq per period", irq_seen, 5);
    wr_reg(3'd2, 0);
    repeat (20) @(negedge clk);
    high_in_window(50, hi);
    check("R3 width 0 keeps pin low", hi, 0);
    wr_reg(3'd2, 12);
    repeat (20) @(negedge clk);
    high_in_window(50, hi);
    check("R3 width above period keeps pin high", hi, 50);
    wr_reg(3'd0, 8'h01);
    repeat (5) @(negedge clk);
    irq_seen = 0;
    repeat (50) @(negedge clk);
    check("R4 no irq with enable clear", irq_seen, 0);
  endtask

  task automatic t_edge();
    int v;
    wr_reg(3'd1, 100);
    wr_reg(3'd0, 8'h12);
    repeat (5) pin_pulse(4, 4);
    repeat (6) @(negedge clk);
    rd_reg(3'd6, v);
    check("R5 count of pin rising edges", v, 5);
    check("R5 pin_oe low in edge mode", int'(pin_oe), 0);
    check("R2 pin_out low outside PWM", int'(pin_out), 0);
    wr_reg(3'd0, 8'h12);
    rd_reg(3'd6, v);
    check("R10 control write restarts count", v, 0);
    wr_reg(3'd1, 3);
    wr_reg(3'd0, 8'h12);
    irq_seen = 0;
    repeat (7) pin_pulse(4, 4);
    repeat (6) @(negedge clk);
    rd_reg(3'd6, v);
    check("R5 count modulo period", v, 1);
    check("R4 edge-mode wraps raise irq", irq_seen, 2);
  endtask

  task automatic t_capture();
    int v;
    wr_reg(3'd0, 8'h13);
    irq_seen = 0;
    repeat (5) @(negedge clk);
    pin_pulse(7, 13);
    rd_reg(3'd3, v);
    check("R7 first rise latches no period", v, 0);
    check("R7 first rise raises no irq", irq_seen, 0);
    repeat (4) pin_pulse(7, 13);
    repeat (2) @(negedge clk);
    rd_reg(3'd3, v);
    check("R6 captured period", v, 20);
    rd_reg(3'd4, v);
    check("R6 captured width", v, 7);
    check("R6 irq per period capture", irq_seen, 4);
    repeat (3) pin_pulse(3, 9);
    rd_reg(3'd3, v);
    check("R6 captured period after change", v, 12);
    rd_reg(3'd4, v);
    check("R6 captured width after change", v, 3);
  endtask

  task automatic t_overflow();
    int v;
    pin_in = 1'b0;
    wr_reg(3'd0, 8'h13);
    err_seen = 0;
    repeat (300) @(negedge clk);
    check("R8 one err_irq on wrap", err_seen, 1);
    rd_reg(3'd5, v);
    check("R8 overflow flag set", v, 1);
    wr_reg(3'd5, 1);
    rd_reg(3'd5, v);
    check("R8 overflow flag cleared", v, 0);
    wr_reg(3'd0, 8'h00);
  endtask

  task automatic t_source();
    wr_reg(3'd1, 4);
    wr_reg(3'd2, 2);
    wr_reg(3'd0, 8'h15);
    irq_seen = 0;
    ext_edges(0, 8);
    repeat (6) @(negedge clk);
    check("R9 ext A edges drive the count", irq_seen, 2);
    repeat (40) @(negedge clk);
    check("R9 system clock ignored with ext A", irq_seen, 2);
    wr_reg(3'd0, 8'h19);
    irq_seen = 0;
    ext_edges(0, 8);
    repeat (6) @(negedge clk);
    check("R9 ext A ignored with ext B selected", irq_seen, 0);
    ext_edges(1, 8);
    repeat (6) @(negedge clk);
    check("R9 ext B edges drive the count", irq_seen, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pwm();
    t_edge();
    t_capture();
    t_overflow();
    t_source();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule